// File: doc/BRIEF.md
# Seconds Watchdog with Reset Pulse and Frequency Reversion

This block supervises system software by counting whole seconds from an external one-second tick. Software programs a 4-bit timeout in seconds; a value of zero leaves the watchdog idle. Each write to the configuration word is the kick: it restarts the count from zero. If the programmed number of ticks arrives with no write in between, the block records a sticky timeout flag. It also drives a fixed-length active-low reset pulse on a shared board pin. After that the count halts until software arms it again.

The shared pin has two roles, set by a mode bit. At 0, the reset default, the pin is an output carrying the reset pulse. At 1 the pin is released and read as an active-low power-down request.

The block also picks the frequency-select code that the clock synthesizer should use. It keeps the last two software-written codes. In normal running it passes on the newest one, or the strapped code if software has never written one. Once a watchdog timeout has been recorded, a reversion bit chooses between two codes. At 0 the block applies the strapped code. At 1 it applies the software code written before the newest one, on the view that the newest code caused the hang.

Top module: `wdt_reset_revert`

## Requirements
- R1: While the stored timeout field is 0 the watchdog never expires, whatever the number of ticks.
- R2: With a stored timeout of t (1 to 15), expiry happens on the t-th tick after the configuration write, and not before.
- R3: Expiry sets the timeout flag. The flag stays set across later writes of a nonzero timeout and is cleared only by a configuration write whose timeout field is 0.
- R4: In mode 0, `sys_rst_n` goes low on the clock after the expiring tick and stays low for exactly PULSE_CLKS (default 16) clocks.
- R5: After expiry the seconds count halts: further ticks give no new expiry or pulse until the next configuration write.
- R6: Any configuration write restarts the seconds count from zero, so a rewrite before the limit postpones expiry by a full period.
- R7: Mode bit 1 releases the pin (`pin_oe` = 0), holds `sys_rst_n` high even on expiry, and passes `pin_in` to `pd_n`. Mode bit 0 drives the pin (`pin_oe` = 1) and holds `pd_n` high.
- R8: Each software code write pushes the previous newest code into the older slot. With the flag clear, `fs_out` is the newest software code, or `strap_fs` if none has been written.
- R9: With the flag set and reversion bit 0, `fs_out` equals `strap_fs`.
- R10: With the flag set and reversion bit 1, `fs_out` is the code written before the newest one, or `strap_fs` if fewer than two codes have been written.
- R11: After reset all configuration fields are 0. `sys_rst_n`, `pin_oe` and `pd_n` are 1, the flag is 0 and `fs_out` equals `strap_fs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sec_tick | input | 1 | One-clock pulse once per second |
| cfg_wr | input | 1 | Configuration write strobe (also the kick) |
| cfg_tmo | input | TMO_W | Timeout in seconds, 0 = off |
| cfg_pin_mode | input | 1 | 0 = pin drives reset, 1 = pin is power-down input |
| cfg_revert | input | 1 | Reversion choice after a watchdog timeout |
| sw_fs_wr | input | 1 | Software frequency code write strobe |
| sw_fs | input | FS_W | Software frequency code |
| strap_fs | input | FS_W | Strapped frequency code |
| pin_in | input | 1 | Level seen on the shared pin |
| sys_rst_n | output | 1 | Active-low reset value for the shared pin |
| pin_oe | output | 1 | Shared pin output enable |
| pd_n | output | 1 | Active-low power-down request |
| tmo_flag | output | 1 | Sticky timeout status |
| fs_out | output | FS_W | Frequency code to apply |

## Verification
The assertions assume that `sec_tick` is high for a single clock. They also assume that no configuration write arrives while a reset pulse is under way, so each pulse runs to its full length. A tick that coincides with a configuration write is treated as lost, and the checks on count timing rely on that. The stimulus places every tick between idle clocks, never on a write cycle, and waits for each pulse to finish before it writes the configuration again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef int unsigned u32_t;

  typedef enum logic [1:0] {
    SRC_STRAP  = 2'd0,
    SRC_LATEST = 2'd1,
    SRC_PRIOR  = 2'd2
  } fs_src_e;

  // Expiry test: the tick now arriving completes the programmed period.
  function automatic logic sec_limit_hit(u32_t elapsed, u32_t limit);
    return (limit != 0) && (elapsed + 1 == limit);
  endfunction

  // Source of the frequency code from flag, reversion choice and history.
  function automatic fs_src_e fs_pick(logic flag, logic revert,
                                      logic cur_vld, logic prev_vld);
    if (flag) begin
      if (revert && prev_vld) return SRC_PRIOR;
      return SRC_STRAP;
    end
    if (cur_vld) return SRC_LATEST;
    return SRC_STRAP;
  endfunction

endpackage

// File: rtl/wdt_sec_count.sv
module wdt_sec_count
  import wdt_pkg::*;
#(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             arm_next,
  input  logic [TMO_W-1:0] limit,
  output logic             expire,
  output logic             armed
);

  logic [TMO_W-1:0] cnt_q;
  logic             armed_q;

  assign armed  = armed_q;
  assign expire = armed_q && tick && !restart &&
                  sec_limit_hit(u32_t'(cnt_q), u32_t'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      armed_q <= arm_next;
    end else if (expire) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q && tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);

  localparam int PW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= PW'(PULSE_CLKS);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

endmodule

// File: rtl/wdt_fs_hist.sv
module wdt_fs_hist #(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [FS_W-1:0] din,
  output logic [FS_W-1:0] cur,
  output logic [FS_W-1:0] prev,
  output logic            cur_vld,
  output logic            prev_vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      prev     <= '0;
      cur_vld  <= 1'b0;
      prev_vld <= 1'b0;
    end else if (wr) begin
      prev     <= cur;
      prev_vld <= cur_vld;
      cur      <= din;
      cur_vld  <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_reset_revert.sv
module wdt_reset_revert
  import wdt_pkg::*;
#(
  parameter int TMO_W      = 4,
  parameter int FS_W       = 4,
  parameter int PULSE_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             cfg_wr,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             cfg_pin_mode,
  input  logic             cfg_revert,
  input  logic             sw_fs_wr,
  input  logic [FS_W-1:0]  sw_fs,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic             pin_in,
  output logic             sys_rst_n,
  output logic             pin_oe,
  output logic             pd_n,
  output logic             tmo_flag,
  output logic [FS_W-1:0]  fs_out
);

  logic [TMO_W-1:0] tmo_q;
  logic             mode_q;
  logic             revert_q;
  logic             flag_q;

  // Named internal events for the checker
  logic             expire_w;
  logic             armed_w;
  logic             pulse_on_w;
  logic [FS_W-1:0]  fs_cur_w, fs_prev_w;
  logic             fs_cur_vld_w, fs_prev_vld_w;
  fs_src_e          fs_src_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q    <= '0;
      mode_q   <= 1'b0;
      revert_q <= 1'b0;
    end else if (cfg_wr) begin
      tmo_q    <= cfg_tmo;
      mode_q   <= cfg_pin_mode;
      revert_q <= cfg_revert;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_q <= 1'b0;
    else if (expire_w)                   flag_q <= 1'b1;
    else if (cfg_wr && cfg_tmo == '0)    flag_q <= 1'b0;
  end

  wdt_sec_count #(.TMO_W(TMO_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .restart  (cfg_wr),
    .arm_next (cfg_tmo != '0),
    .limit    (tmo_q),
    .expire   (expire_w),
    .armed    (armed_w)
  );

  wdt_rst_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (expire_w),
    .active (pulse_on_w)
  );

  wdt_fs_hist #(.FS_W(FS_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (sw_fs_wr),
    .din      (sw_fs),
    .cur      (fs_cur_w),
    .prev     (fs_prev_w),
    .cur_vld  (fs_cur_vld_w),
    .prev_vld (fs_prev_vld_w)
  );

  assign fs_src_w = fs_pick(flag_q, revert_q, fs_cur_vld_w, fs_prev_vld_w);

  always_comb begin
    unique case (fs_src_w)
      SRC_LATEST: fs_out = fs_cur_w;
      SRC_PRIOR:  fs_out = fs_prev_w;
      default:    fs_out = strap_fs;
    endcase
  end

  assign tmo_flag  = flag_q;
  assign pin_oe    = ~mode_q;
  assign sys_rst_n = mode_q | ~pulse_on_w;
  assign pd_n      = mode_q ? pin_in : 1'b1;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int TMO_W      = 4,
  parameter int FS_W       = 4,
  parameter int PULSE_CLKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             expire,
  input logic             pulse_on,
  input logic [TMO_W-1:0] tmo_q,
  input logic             mode_q,
  input logic             revert_q,
  input logic             sys_rst_n,
  input logic             pin_oe,
  input logic             pd_n,
  input logic             tmo_flag,
  input logic [FS_W-1:0]  fs_out,
  input logic [FS_W-1:0]  strap_fs
);

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= 0;
    else if (pulse_on) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  // R1
  off_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q == '0) |-> !expire);

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_flag);

  // R3
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(expire));

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q) |=> !sys_rst_n);

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_on) |-> (run_len == PULSE_CLKS));

  // R4
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= PULSE_CLKS);

  // R7
  released_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> sys_rst_n);

  // R7
  driven_pin_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> pd_n);

  // R9
  strap_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !revert_q) |-> (fs_out == strap_fs));

endmodule

bind wdt_reset_revert wdt_chk #(
  .TMO_W(TMO_W), .FS_W(FS_W), .PULSE_CLKS(PULSE_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .expire   (expire_w),
  .pulse_on (pulse_on_w),
  .tmo_q    (tmo_q),
  .mode_q   (mode_q),
  .revert_q (revert_q),
  .sys_rst_n(sys_rst_n),
  .pin_oe   (pin_oe),
  .pd_n     (pd_n),
  .tmo_flag (tmo_flag),
  .fs_out   (fs_out),
  .strap_fs (strap_fs)
);

// File: tb/sim_wdt_reset_revert.sv
module sim_wdt_reset_revert;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_tmo = '0;
  logic       cfg_pin_mode = 1'b0;
  logic       cfg_revert = 1'b0;
  logic       sw_fs_wr = 1'b0;
  logic [3:0] sw_fs = '0;
  logic [3:0] strap_fs = 4'h3;
  logic       pin_in = 1'b1;
  logic       sys_rst_n, pin_oe, pd_n, tmo_flag;
  logic [3:0] fs_out;

  int errors = 0;
  int checks = 0;
  int low_cnt = 0;

  always #2.5 clk = ~clk;

  wdt_reset_revert u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cfg_wr(cfg_wr),
    .cfg_tmo(cfg_tmo), .cfg_pin_mode(cfg_pin_mode), .cfg_revert(cfg_revert),
    .sw_fs_wr(sw_fs_wr), .sw_fs(sw_fs), .strap_fs(strap_fs), .pin_in(pin_in),
    .sys_rst_n(sys_rst_n), .pin_oe(pin_oe), .pd_n(pd_n),
    .tmo_flag(tmo_flag), .fs_out(fs_out)
  );

  // Counts every sampled low level on the reset output
  always @(negedge clk) if (rst_n && !sys_rst_n) low_cnt <= low_cnt + 1;

  // {timeout[3:0], ticks[7:0], expect_expiry}
  localparam logic [12:0] VEC [9] = '{
    {4'd1,  8'd0,  1'b0}, {4'd1,  8'd1,  1'b1},
    {4'd2,  8'd1,  1'b0}, {4'd2,  8'd2,  1'b1},
    {4'd5,  8'd4,  1'b0}, {4'd5,  8'd5,  1'b1},
    {4'd15, 8'd14, 1'b0}, {4'd15, 8'd15, 1'b1},
    {4'd0,  8'd20, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] t, input logic m, input logic r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tmo = t; cfg_pin_mode = m; cfg_revert = r;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic tick1;
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick1();
      idle(2);
    end
  endtask

  task automatic swfs(input logic [3:0] v);
    @(negedge clk);
    sw_fs_wr = 1'b1; sw_fs = v;
    @(negedge clk);
    sw_fs_wr = 1'b0;
  endtask

  task automatic run_all;
    int base;
    int n;
    // R11 reset state
    chk("R11 sys_rst_n", sys_rst_n, 1);
    chk("R11 pin_oe", pin_oe, 1);
    chk("R11 pd_n", pd_n, 1);
    chk("R11 flag", tmo_flag, 0);
    chk("R11 fs_out", fs_out, 4'h3);
    ticks(3);
    chk("R1 reset default off", tmo_flag, 0);

    // Table walk: R1 R2
    for (int v = 0; v < 9; v++) begin
      cfg(4'd0, 1'b0, 1'b0);
      idle(20);
      base = low_cnt;
      cfg(VEC[v][12:9], 1'b0, 1'b0);
      ticks(int'(VEC[v][8:1]));
      idle(20);
      chk(VEC[v][12:9] == 0 ? "R1 flag" : "R2 flag", tmo_flag, int'(VEC[v][0]));
      chk(VEC[v][12:9] == 0 ? "R1 pulse" : "R2 pulse", (low_cnt != base) ? 1 : 0,
          int'(VEC[v][0]));
    end

    // R4 exact pulse length
    cfg(4'd0, 1'b0, 1'b0);
    cfg(4'd1, 1'b0, 1'b0);
    idle(2);
    tick1();
    n = 0;
    while (!sys_rst_n && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R4 pulse length", n, 16);

    // R3 flag kept by nonzero write, cleared by zero write
    chk("R3 flag after expiry", tmo_flag, 1);
    cfg(4'd3, 1'b0, 1'b0);
    chk("R3 flag kept", tmo_flag, 1);
    cfg(4'd0, 1'b0, 1'b0);
    chk("R3 flag cleared", tmo_flag, 0);

    // R5 halt after expiry
    cfg(4'd2, 1'b0, 1'b0);
    ticks(2);
    idle(20);
    base = low_cnt;
    ticks(10);
    idle(5);
    chk("R5 no second pulse", (low_cnt != base) ? 1 : 0, 0);

    // R6 kick restarts count
    cfg(4'd0, 1'b0, 1'b0);
    base = low_cnt;
    cfg(4'd3, 1'b0, 1'b0);
    ticks(2);
    cfg(4'd3, 1'b0, 1'b0);
    ticks(2);
    chk("R6 no expiry after kick", tmo_flag, 0);
    ticks(1);
    chk("R6 expiry one period after kick", tmo_flag, 1);
    idle(20);

    // R7 power-down mode
    cfg(4'd0, 1'b0, 1'b0);
    pin_in = 1'b0;
    idle(1);
    chk("R7 mode0 oe", pin_oe, 1);
    chk("R7 mode0 pd_n", pd_n, 1);
    cfg(4'd1, 1'b1, 1'b0);
    chk("R7 mode1 oe", pin_oe, 0);
    chk("R7 mode1 pd_n low", pd_n, 0);
    pin_in = 1'b1;
    idle(1);
    chk("R7 mode1 pd_n high", pd_n, 1);
    base = low_cnt;
    ticks(1);
    idle(20);
    chk("R7 mode1 flag", tmo_flag, 1);
    chk("R7 mode1 no drive low", (low_cnt != base) ? 1 : 0, 0);

    // R8 R9 R10 frequency selection
    cfg(4'd0, 1'b0, 1'b0);
    chk("R8 no sw code", fs_out, 4'h3);
    swfs(4'hA);
    chk("R8 newest code", fs_out, 4'hA);
    cfg(4'd1, 1'b0, 1'b1);
    ticks(1);
    idle(20);
    chk("R10 one code only", fs_out, 4'h3);
    cfg(4'd0, 1'b0, 1'b1);
    chk("R8 after flag clear", fs_out, 4'hA);
    swfs(4'h5);
    chk("R8 history shift", fs_out, 4'h5);
    cfg(4'd1, 1'b0, 1'b1);
    ticks(1);
    idle(20);
    chk("R10 prior code", fs_out, 4'hA);
    cfg(4'd2, 1'b0, 1'b0);
    chk("R9 strap on flag", fs_out, 4'h3);
    cfg(4'd0, 1'b0, 1'b0);
    chk("R8 newest again", fs_out, 4'h5);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1..all actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule